// File: doc/BRIEF.md
# Iterative Subtract-Until-Not-Greater Unit

This sequential unit evaluates the loop "while a exceeds b, replace a by a minus b" on two operands and returns the value of a once the loop stops. A single start strobe captures both operands and a mode bit that selects unsigned or two's-complement interpretation. Later, a one-cycle done strobe presents the final value. A second flag on that strobe shows whether the run was cut short.

Only one adder is used. It does the comparison and the subtraction in separate cycles. In both cases it adds the bitwise inverse of the second operand with carry-in 1. The comparison result is the sum's top bit XOR the signed overflow flag, taken one bit wider than the operands so that both modes share the same path. Each loop pass costs a compare step followed by a subtract step. Operands that would never let the loop stop (a zero or, in signed mode, negative b) are caught by an iteration limit.

Top module: `iter_sub_unit`

## Requirements
- R1: After reset, `done_o` is 0, `err_o` is 0 and `res_o` is 0.
- R2: With `sgn_i`=0 the operands are unsigned. The result is a after repeated subtraction of b, stopping as soon as a is less than or equal to b.
- R3: With `sgn_i`=1 both operands are two's-complement values, and the comparison and the subtraction are signed.
- R4: If a is not greater than b at start, `res_o` equals the original a. `done_o` is high after the second rising edge following the edge that samples `start_i`.
- R5: A run with k subtractions raises `done_o` after exactly 2+2k rising edges following the start edge.
- R6: `done_o` is high for exactly one cycle. `res_o` and `err_o` hold their values until the next completion.
- R7: If the loop condition is still true after MAX_ITER subtractions, the run ends with `err_o`=1. `res_o` then holds a after MAX_ITER subtractions, and `done_o` rises 2+2*MAX_ITER edges after start.
- R8: `start_i` is ignored while a run is in progress. The operands and the timing of the current run are unaffected.
- R9: a equal to b counts as not greater, so the loop stops there (for example 14 and 7 gives 7).
- R10: A run that finishes normally reports `err_o`=0, even right after an aborted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a run when the unit is idle |
| sgn_i | input | 1 | 1 = signed operands, 0 = unsigned, sampled with start |
| a_i | input | WIDTH | Initial value of a |
| b_i | input | WIDTH | Value subtracted, held for the whole run |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Run aborted by the iteration limit, valid from done |
| res_o | output | WIDTH | Final value of a |

## Verification
A wrong condition flag or a bad mux or demux select shows up at the first done strobe. It appears either as a result that is still greater than b or as a latency that is not 2+2k. Both are checked on every run. A stuck iteration counter leaves the error flag wrong, or moves done off the 2+2*MAX_ITER edge, in the abort scenarios. A controller that reacts to a start during a run shifts the done cycle or the result of the current run, and that is visible at the first completion.

// File: rtl/iter_sub_pkg.sv
// Package: shared state encoding for the iterative subtract unit.
package iter_sub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_SUB  = 2'd2
    } loop_st_t;
endpackage

// File: rtl/iter_sub_adder.sv
// Module: shared add/subtract unit. It forms x + ~y + 1 and reports
// whether x < y (signed) as sum MSB xor overflow.
// Assumes: operands are already extended to EW bits by the caller.
module iter_sub_adder #(
    parameter int EW = 17
) (
    input  logic [EW-1:0] x_i,
    input  logic [EW-1:0] y_i,
    output logic [EW-1:0] sum_o,
    output logic          neg_o
);
    logic [EW-1:0] y_inv;
    logic          ovf;

    // Two's-complement subtraction through inversion and carry-in.
    always_comb begin
        y_inv = ~y_i;
        sum_o = x_i + y_inv + {{(EW-1){1'b0}}, 1'b1};
        ovf   = (x_i[EW-1] == y_inv[EW-1]) && (sum_o[EW-1] != x_i[EW-1]);
        neg_o = sum_o[EW-1] ^ ovf;
    end

    // R2 R3: the flag agrees with a signed comparison of the operands
    always_comb begin
        lt_flag_chk: assert (neg_o == ($signed(x_i) < $signed(y_i)));
    end
endmodule

// File: rtl/iter_sub_ctrl.sv
// Module: controller FSM. It runs the compare step, then the subtract or
// finish step, and counts subtractions against MAX_ITER.
// Assumes: cond_i is the registered a>b flag written during the compare step.
module iter_sub_ctrl
    import iter_sub_pkg::*;
#(
    parameter int MAX_ITER = 64,
    localparam int CW = $clog2(MAX_ITER + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cond_i,
    output logic load_o,
    output logic cmp_o,
    output logic sub_o,
    output logic fin_o,
    output logic abort_o
);
    loop_st_t      st_q;
    logic [CW-1:0] cnt_q;
    logic          hit;

    // Decode control strobes from state, flag and counter.
    always_comb begin
        hit     = (cnt_q == CW'(MAX_ITER));
        load_o  = (st_q == ST_IDLE) && start_i;
        cmp_o   = (st_q == ST_CMP);
        sub_o   = (st_q == ST_SUB) && cond_i && !hit;
        abort_o = (st_q == ST_SUB) && cond_i && hit;
        fin_o   = (st_q == ST_SUB) && (!cond_i || hit);
    end

    // State sequencing: idle -> compare -> subtract/finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (start_i) st_q <= ST_CMP;
                ST_CMP:  st_q <= ST_SUB;
                ST_SUB:  st_q <= fin_o ? ST_IDLE : ST_CMP;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Subtraction counter, cleared on each new run.
    always_ff @(posedge clk) begin
        if (!rst_n || load_o) cnt_q <= '0;
        else if (sub_o)       cnt_q <= cnt_q + 1'b1;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_ITER));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> !load_o);
endmodule

// File: rtl/iter_sub_datapath.sv
// Module: operand registers, condition flag and final-result register
// around the shared adder. A mux picks the adder operands and a demux
// routes the sum to the condition flag or back to register a.
// Assumes: control strobes from iter_sub_ctrl are mutually exclusive.
module iter_sub_datapath #(
    parameter int WIDTH = 16,
    localparam int EW = WIDTH + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             cmp_i,
    input  logic             sub_i,
    input  logic             fin_i,
    input  logic             abort_i,
    input  logic             sgn_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             cond_o,
    output logic             done_o,
    output logic             err_o,
    output logic [WIDTH-1:0] res_o
);
    logic [EW-1:0] a_q, b_q, x, y, sum;
    logic          neg;
    logic          ext_a, ext_b;

    // Operand mux: compare forms b - a, subtract forms a - b.
    always_comb begin
        x     = cmp_i ? b_q : a_q;
        y     = cmp_i ? a_q : b_q;
        ext_a = sgn_i & a_i[WIDTH-1];
        ext_b = sgn_i & b_i[WIDTH-1];
    end

    iter_sub_adder #(.EW(EW)) u_add (
        .x_i  (x),
        .y_i  (y),
        .sum_o(sum),
        .neg_o(neg)
    );

    // Operand registers: load extended inputs, write back the difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load_i) begin
            a_q <= {ext_a, a_i};
            b_q <= {ext_b, b_i};
        end else if (sub_i) begin
            a_q <= sum;
        end
    end

    // Condition flag: false on start, set from the compare step.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) cond_o <= 1'b0;
        else if (cmp_i)       cond_o <= neg;
    end

    // Final register, completion strobe and abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o  <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                res_o <= a_q[WIDTH-1:0];
                err_o <= abort_i;
            end
        end
    end

    // R2 R9: a normal finish only happens once a is not greater than b
    final_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && !abort_i) |-> !($signed(a_q) > $signed(b_q)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(res_o));
endmodule

// File: rtl/iter_sub_unit.sv
// Module: top of the iterative subtract-until-not-greater unit.
// Assumes: start is honoured only while idle; results are valid with done.
module iter_sub_unit #(
    parameter int WIDTH    = 16,
    parameter int MAX_ITER = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sgn_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             done_o,
    output logic             err_o,
    output logic [WIDTH-1:0] res_o
);
    logic load, cmp, sub, fin, abort, cond;

    iter_sub_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .cond_i (cond),
        .load_o (load),
        .cmp_o  (cmp),
        .sub_o  (sub),
        .fin_o  (fin),
        .abort_o(abort)
    );

    iter_sub_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .cmp_i  (cmp),
        .sub_i  (sub),
        .fin_i  (fin),
        .abort_i(abort),
        .sgn_i  (sgn_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .cond_o (cond),
        .done_o (done_o),
        .err_o  (err_o),
        .res_o  (res_o)
    );

    // R7: the error flag is only raised together with done
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
endmodule

// File: tb/iter_sub_unit_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module iter_sub_unit_bench;
    localparam int W  = 16;
    localparam int MX = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic         done, err;
    logic [W-1:0] res;
    int           total = 0, bad = 0;
    bit           finished = 1'b0;

    always #2 clk = ~clk;

    iter_sub_unit #(.WIDTH(W), .MAX_ITER(MX)) u_iter_sub_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sgn_i(sgn),
        .a_i(a), .b_i(b), .done_o(done), .err_o(err), .res_o(res)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference loop: returns final a, subtraction count and abort flag.
    task automatic model(input logic s, input logic [W-1:0] ai, input logic [W-1:0] bi,
                         output logic [W-1:0] r, output int k, output bit ab);
        longint av = s ? longint'($signed(ai)) : longint'(ai);
        longint bv = s ? longint'($signed(bi)) : longint'(bi);
        k  = 0;
        ab = 1'b0;
        while (av > bv) begin
            if (k == MX) begin ab = 1'b1; break; end
            av = av - bv;
            k++;
        end
        r = W'(av);
    endtask

    // Start a run and return the number of edges until done is seen.
    task automatic launch(input logic s, input logic [W-1:0] ai, input logic [W-1:0] bi,
                          input bit poke, output int cyc);
        @(negedge clk);
        sgn = s; a = ai; b = bi; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (cyc < 400) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (poke && cyc == 3) begin
                start = 1'b1; a = 16'd9; b = 16'd1; sgn = 1'b0;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
    endtask

    task automatic run_case(input string req, input logic s, input logic [W-1:0] ai,
                            input logic [W-1:0] bi, input bit poke);
        logic [W-1:0] er;
        int ek, cyc;
        bit eab;
        model(s, ai, bi, er, ek, eab);
        launch(s, ai, bi, poke, cyc);
        check({req, " result"}, res, er);
        check({req, " latency R5"}, cyc, 2 + 2 * ek);
        check({req, " err R10"}, err, eab);
        @(negedge clk);
        check({req, " done pulse R6"}, done, 0);
        check({req, " result hold R6"}, res, er);
    endtask

    task automatic t_reset();
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        check("R1 res", res, 0);
    endtask

    task automatic t_unsigned();
        run_case("R2 100/7", 1'b0, 16'd100, 16'd7, 1'b0);
        run_case("R2 big", 1'b0, 16'hF000, 16'h1000, 1'b0);
        run_case("R9 equal stop", 1'b0, 16'd14, 16'd7, 1'b0);
    endtask

    task automatic t_signed();
        run_case("R3 pos", 1'b1, 16'd50, 16'd12, 1'b0);
        run_case("R3 neg not greater", 1'b1, 16'hFFFB, 16'hFFFD, 1'b0);
        run_case("R3 neg loop", 1'b1, 16'hFFFE, 16'hFFF0, 1'b0);
        // 0xFFFB is large unsigned: must loop in unsigned mode
        run_case("R2 same bits unsigned", 1'b0, 16'hFFFB, 16'h7000, 1'b0);
    endtask

    task automatic t_entry();
        run_case("R4 a<b", 1'b0, 16'd3, 16'd9, 1'b0);
        run_case("R4 zero", 1'b0, 16'd0, 16'd0, 1'b0);
    endtask

    task automatic t_abort();
        run_case("R7 b zero", 1'b0, 16'd5, 16'd0, 1'b0);
        run_case("R7 b negative", 1'b1, 16'd3, 16'hFFFF, 1'b0);
        run_case("R10 clean after abort", 1'b0, 16'd20, 16'd6, 1'b0);
        run_case("R7 exact limit", 1'b0, 16'd65, 16'd1, 1'b0);
    endtask

    task automatic t_busy();
        run_case("R8 start ignored", 1'b0, 16'd40, 16'd5, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unsigned();
        t_signed();
        t_entry();
        t_abort();
        t_busy();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule